// File: doc/BRIEF.md
# Word-Address Pointer Incrementer with Block Carry Skip

This block holds a 30-bit word-address pointer and steps it forward by one on request. The two least significant byte-address bits are always zero for a word pointer, so only the upper 30 bits are stored. The next value is formed in two phases. First every carry is resolved. Then each bit is toggled in parallel by its own carry. The carry into a bit is asserted exactly when all lower bits are one, so the lowest zero bit absorbs the increment.

Carries come from two cooperating paths. A per-bit chain of pass elements carries an active-low carry upward. A skip network groups the bits into fixed blocks of 3, 4, 5, 6, 6 and 6 bits, counted from the least significant end. A block forwards the carry to the next block only when all of its bits are ones, so long runs of trailing ones do not pay the full ripple delay. A plain full-width chain is built next to the skip network and kept as a reference. Its carries must match the skip result at every cycle.

The pointer can be loaded with an arbitrary value, and loading wins over stepping. The result is registered on the rising clock edge. A pointer of all ones steps to zero and raises a one-cycle wrap flag.

Top module: `wordptr_bump`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, ptr_q reads 0 and wrap_q reads 0.
- R2: When load_en is 1 at a rising edge, ptr_q takes load_val after that edge.
- R3: When load_en and step_en are both 1 at the same edge, only the load takes effect: ptr_q equals load_val and wrap_q is 0, even when the old pointer is all ones.
- R4: When step_en is 1 and load_en is 0 at an edge, ptr_q becomes (old ptr_q + 1) modulo 2^30. The carry into bit i is set exactly when bits 0 to i-1 of the old value are all 1.
- R5: A step from all ones (30'h3FFFFFFF) gives ptr_q = 0 and wrap_q = 1 for exactly that cycle. wrap_q is 0 after any edge that does not perform such a step.
- R6: When load_en and step_en are both 0, ptr_q holds its value and wrap_q is 0.
- R7: For every count of trailing ones from 0 to 30, the block-skip carries equal the plain chain carries, so the stepped result is correct whichever block boundary the lowest zero falls in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Replace the pointer with load_val; takes priority over step_en |
| load_val | input | 30 | Word address to load |
| step_en | input | 1 | Advance the pointer by one word |
| ptr_q | output | 30 | Registered word-address pointer |
| wrap_q | output | 1 | One-cycle pulse after a step from all ones to zero |

## Verification
Load and step can both be requested at the same edge. The bench provokes this with the pointer parked at all ones, then checks that the loaded value appears and that no wrap pulse is raised. It also checks the case where the loaded value is itself all ones. The chain and skip paths are judged against each other by an in-design assertion. At the ports they are judged by stepping values whose lowest zero sits at every bit position, including each block edge, and comparing the result with an arithmetic +1 worked out in the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned PTR_W = 30;
  localparam int unsigned NGRP  = 6;
  // skip block sizes, least significant block first
  localparam int unsigned GSZ [NGRP] = '{3, 4, 5, 6, 6, 6};

  // first bit index of block g (g == NGRP gives the total width)
  function automatic int unsigned grp_lo(input int unsigned g);
    int unsigned s;
    s = 0;
    for (int unsigned k = 0; k < NGRP; k++) begin
      if (k < g) s += GSZ[k];
    end
    return s;
  endfunction
endpackage

// File: rtl/wp_chain.sv
// Reference carry chain: one pass element per bit, carry held active-low.
module wp_chain #(
  parameter int unsigned W = wp_pkg::PTR_W
) (
  input  logic [W-1:0] a,
  output logic [W:0]   cy_n
);
  // carry into bit 0 is always present for a +1
  assign cy_n[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_pass
    // a one passes the incoming carry; a zero kills it (drives inactive high)
    assign cy_n[i+1] = a[i] ? cy_n[i] : 1'b1;
  end
endmodule

// File: rtl/wp_skip.sv
// Block skip network: a block forwards its carry only when it is all ones.
module wp_skip #(
  parameter int unsigned W    = wp_pkg::PTR_W,
  parameter int unsigned NG   = wp_pkg::NGRP
) (
  input  logic [W-1:0]  a,
  output logic [NG-1:0] blk_all,
  output logic [NG-1:0] blk_cin
);
  import wp_pkg::*;

  for (genvar g = 0; g < NG; g++) begin : g_blk
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned SZ = GSZ[g];
    assign blk_all[g] = &a[LO +: SZ];
    if (g == 0) begin : g_first
      assign blk_cin[g] = 1'b1;
    end else begin : g_rest
      assign blk_cin[g] = blk_cin[g-1] & blk_all[g-1];
    end
  end
endmodule

// File: rtl/wp_merge.sv
// Local in-block chains seeded by the skip carries, then parallel toggle.
module wp_merge #(
  parameter int unsigned W  = wp_pkg::PTR_W,
  parameter int unsigned NG = wp_pkg::NGRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [NG-1:0] blk_all,
  input  logic [NG-1:0] blk_cin,
  input  logic [W:0]    ref_cy_n,
  output logic [W-1:0]  sum,
  output logic          cout
);
  import wp_pkg::*;

  logic [W-1:0] cin_n;

  for (genvar g = 0; g < NG; g++) begin : g_blk
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned SZ = GSZ[g];
    for (genvar j = 0; j < SZ; j++) begin : g_bit
      if (j == 0) begin : g_seed
        assign cin_n[LO] = ~blk_cin[g];
      end else begin : g_link
        assign cin_n[LO+j] = a[LO+j-1] ? cin_n[LO+j-1] : 1'b1;
      end
    end
  end

  // every bit flips where its carry is present
  assign sum  = a ^ ~cin_n;
  assign cout = blk_cin[NG-1] & blk_all[NG-1];

  // R7: skip-derived carries agree with the plain ripple chain
  assert_skip_eq_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_n == ref_cy_n[W-1:0]) && (cout == ~ref_cy_n[W]));
endmodule

// File: rtl/wordptr_bump.sv
module wordptr_bump #(
  parameter int unsigned PTR_W = wp_pkg::PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step_en,
  output logic [PTR_W-1:0] ptr_q,
  output logic             wrap_q
);
  import wp_pkg::*;
  localparam int unsigned NG = NGRP;
  localparam logic [PTR_W-1:0] ALL1 = '1;

  if (grp_lo(NG) != PTR_W) begin : g_bad_groups
    $error("skip block sizes do not cover the pointer width");
  end

  logic [PTR_W:0]   chain_cy_n;
  logic [NG-1:0]    blk_all, blk_cin;
  logic [PTR_W-1:0] nxt;
  logic             nxt_wrap;

  wp_chain #(.W(PTR_W)) u_chain (
    .a    (ptr_q),
    .cy_n (chain_cy_n)
  );

  wp_skip #(.W(PTR_W), .NG(NG)) u_skip (
    .a       (ptr_q),
    .blk_all (blk_all),
    .blk_cin (blk_cin)
  );

  wp_merge #(.W(PTR_W), .NG(NG)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .a        (ptr_q),
    .blk_all  (blk_all),
    .blk_cin  (blk_cin),
    .ref_cy_n (chain_cy_n),
    .sum      (nxt),
    .cout     (nxt_wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_en) begin
        ptr_q <= load_val;
      end else if (step_en) begin
        ptr_q  <= nxt;
        wrap_q <= nxt_wrap;
      end
    end
  end

  // R2 / R3: a load always lands, step or not
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (ptr_q == $past(load_val)) && !wrap_q);
  // R4: a step alone advances by exactly one word
  assert_step_plus1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> ptr_q == $past(ptr_q) + 1'b1);
  // R5: wrap pulse only with a zero pointer, and always after a step from all ones
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> ptr_q == '0);
  assert_wrap_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && ptr_q == ALL1) |=> wrap_q);
  // R6: idle keeps the pointer
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(ptr_q) && !wrap_q);
endmodule

// File: tb/tb_wordptr_bump.sv
`timescale 1ns/1ps
module tb_wordptr_bump;
  localparam int W = 30;
  localparam logic [W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic step_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] ptr_q;
  logic wrap_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wordptr_bump dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .step_en(step_en), .ptr_q(ptr_q), .wrap_q(wrap_q)
  );

  // start value, expected after one step
  localparam logic [2*W-1:0] VEC [8] = '{
    {30'h00000000, 30'h00000001},
    {30'h00000007, 30'h00000008},
    {30'h0000007F, 30'h00000080},
    {30'h00000FFF, 30'h00001000},
    {30'h0001FFFF, 30'h00020000},
    {30'h00FFFFFF, 30'h01000000},
    {30'h15555555, 30'h15555556},
    {30'h1FFFFFFF, 30'h20000000}
  };

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller is at a falling edge; inputs held across one rising edge
  task automatic cyc(input logic ld, input logic [W-1:0] v, input logic st);
    load_en = ld; load_val = v; step_en = st;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 in reset", {wrap_q, ptr_q}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {wrap_q, ptr_q}, '0);

    // table walk: load, then step
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, VEC[i][2*W-1:W], 1'b0);
      chk("R2 load", {wrap_q, ptr_q}, {1'b0, VEC[i][2*W-1:W]});
      cyc(1'b0, '0, 1'b1);
      chk("R4 table step", {wrap_q, ptr_q}, {1'b0, VEC[i][W-1:0]});
    end

    // every trailing-ones count, lowest zero at each bit incl. block edges
    for (int k = 0; k <= W; k++) begin
      logic [W:0] lowm;
      logic [W-1:0] v, e;
      lowm = (31'd1 << k) - 31'd1;
      v = lowm[W-1:0] | (30'h2AAAAAAA & ~(lowm[W-1:0] | (30'd1 << k)));
      e = v + 30'd1;
      cyc(1'b1, v, 1'b0);
      cyc(1'b0, '0, 1'b1);
      chk($sformatf("R7 trailing ones %0d", k), {wrap_q, ptr_q}, {(k == W), e});
    end

    // random values
    for (int n = 0; n < 24; n++) begin
      logic [W-1:0] v;
      v = W'($urandom);
      cyc(1'b1, v, 1'b0);
      cyc(1'b0, '0, 1'b1);
      chk("R4 random step", {wrap_q, ptr_q}, {(v == ALL1), v + 30'd1});
    end

    // wrap pulse lasts one cycle
    cyc(1'b1, ALL1, 1'b0);
    cyc(1'b0, '0, 1'b1);
    chk("R5 wrap", {wrap_q, ptr_q}, {1'b1, 30'd0});
    cyc(1'b0, '0, 1'b1);
    chk("R5 wrap clears", {wrap_q, ptr_q}, {1'b0, 30'd1});

    // idle holds
    cyc(1'b0, 30'h12345678, 1'b0);
    chk("R6 idle", {wrap_q, ptr_q}, {1'b0, 30'd1});

    // load and step together with pointer at all ones
    cyc(1'b1, ALL1, 1'b0);
    cyc(1'b1, 30'h0ABCDEF0, 1'b1);
    chk("R3 load beats step", {wrap_q, ptr_q}, {1'b0, 30'h0ABCDEF0});
    cyc(1'b1, ALL1, 1'b1);
    chk("R3 load all ones no wrap", {wrap_q, ptr_q}, {1'b0, ALL1});

    // synchronous reset mid-run
    rst_n = 1'b0;
    cyc(1'b0, '0, 1'b1);
    chk("R1 reset mid-run", {wrap_q, ptr_q}, '0);
    rst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule